// File: doc/BRIEF.md
# Two-Colour Hardware Cursor Overlay

This block sits in a display pixel stream and paints a small two-colour pointer over the picture. Software loads a cursor shape as one mask word and one colour-select word per cursor row, then places the cursor with a single position word. For every pixel that enters the block, it checks whether the pixel lies inside the cursor box and whether the cursor is drawn there. A drawn pixel has its colour index replaced by one of two overlay palette entries. Any other pixel leaves with its own index, widened by one bit.

The output is one pixel stream of palette indices, delayed by one register stage. The palette lookup and the raster timing belong to neighbouring blocks. A cursor box that reaches past the right edge of the screen is cut at the last visible column. A cursor whose X position is at or beyond the screen width is not shown at all. Reset moves the cursor far off screen, so nothing is drawn until software places it.

A general-purpose control word is also provided. It keeps whatever software writes to it, and a read of it always shows one status flag set.

Top module: `hwcur_overlay`

## Requirements
- R1: While reset is held and on the first cycles after it, `out_valid` is 0. Reset loads 0xF000 into both cursor X and cursor Y, so no pixel is covered until the position is written.
- R2: `out_valid` and `out_index` show the pixel presented one clock earlier. `out_valid` equals the `pix_valid` of that earlier cycle.
- R3: A pixel outside the cursor box leaves as its 8-bit index with a 0 added in bit 8.
- R4: Inside the box, a mask bit of 0 lets the pixel through unchanged. A mask bit of 1 gives index 259 (0x103) when the matching colour-select bit is 1, and index 258 (0x102) when it is 0.
- R5: In each row word, bit 31 belongs to column X. Each lower bit moves one column to the right, so bit 0 belongs to column X+31.
- R6: Cursor row k (0..31) is drawn on screen row Y+k. Its mask word is at byte offset 0x900+4k and its colour-select word is at 0x980+4k. Rows above Y and below Y+31 are never covered.
- R7: The cursor is shown only when X is less than the screen width `SCREEN_W` (default 1024). Columns at or beyond `SCREEN_W` are never covered, so the drawn span is clipped to `SCREEN_W`−X pixels.
- R8: A write to offset 0x8FC sets X from data bits 31:16 and Y from data bits 15:0.
- R9: Offset 0x818 keeps the last value written to it. A read of 0x818 returns that value ORed with 0x02000000. A read of any other offset returns 0.
- R10: A register write changes the output for pixels presented in the cycle after the write. A pixel presented in the same cycle as the write still sees the old setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset, used for both writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pix_valid | input | 1 | Pixel qualifier |
| pix_x | input | 16 | Pixel column |
| pix_y | input | 16 | Pixel row |
| pix_index | input | 8 | Colour index of the underlying pixel |
| out_valid | output | 1 | Delayed pixel qualifier |
| out_index | output | 9 | Palette index after the overlay |

## Verification
The assertions assume that the register and pixel inputs hold steady for the whole of each clock cycle. They also assume that pixel coordinates are plain unsigned screen positions, so the pass-through checks above and left of the cursor compare them directly against the stored position. The bench changes every input on the falling clock edge and only uses coordinates below 0x1000. It checks each pixel against a model of the cursor state that it keeps itself and updates as it writes the registers. The model's state takes effect from the next presented pixel, which matches the way the stimulus is ordered.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;
   localparam int unsigned REG_W   = 32;
   localparam int unsigned ADDR_W  = 12;
   localparam int unsigned COORD_W = 16;

   localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h818;
   localparam logic [ADDR_W-1:0] OFS_PLACE = 12'h8FC;
   localparam logic [ADDR_W-1:0] OFS_SHAPE = 12'h900;
   localparam logic [ADDR_W-1:0] OFS_TINT  = 12'h980;

   localparam logic [REG_W-1:0]   CTRL_FLAG  = 32'h0200_0000;
   localparam logic [COORD_W-1:0] PARK_POS   = 16'hF000;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_CTRL,
      TGT_PLACE,
      TGT_SHAPE,
      TGT_TINT
   } reg_target_e;
endpackage

// File: rtl/hwcur_regs.sv
module hwcur_regs
   import hwcur_pkg::*;
#(
   parameter int unsigned CUR_SIZE = 32,
   localparam int unsigned ROW_W   = (CUR_SIZE > 1) ? $clog2(CUR_SIZE) : 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [REG_W-1:0]                 wdata,
   output logic [REG_W-1:0]                 rdata,
   output logic [COORD_W-1:0]               place_x,
   output logic [COORD_W-1:0]               place_y,
   output logic [CUR_SIZE-1:0][REG_W-1:0]   shape_rows,
   output logic [CUR_SIZE-1:0][REG_W-1:0]   tint_rows
);
   localparam int unsigned SPAN_BYTES = 4 * CUR_SIZE;

   reg_target_e          target;
   logic [ADDR_W-1:0]    shape_off;
   logic [ADDR_W-1:0]    tint_off;
   logic [ROW_W-1:0]     row_sel;
   logic [REG_W-1:0]     ctrl_q;

   assign shape_off = addr - OFS_SHAPE;
   assign tint_off  = addr - OFS_TINT;

   always_comb begin
      target  = TGT_NONE;
      row_sel = '0;
      if (addr == OFS_CTRL) begin
         target = TGT_CTRL;
      end else if (addr == OFS_PLACE) begin
         target = TGT_PLACE;
      end else if (addr >= OFS_SHAPE && 32'(addr) < 32'(OFS_SHAPE) + SPAN_BYTES) begin
         target  = TGT_SHAPE;
         row_sel = shape_off[ROW_W+1:2];
      end else if (addr >= OFS_TINT && 32'(addr) < 32'(OFS_TINT) + SPAN_BYTES) begin
         target  = TGT_TINT;
         row_sel = tint_off[ROW_W+1:2];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         place_x <= PARK_POS;
         place_y <= PARK_POS;
      end else if (wr) begin
         if (target == TGT_CTRL) begin
            ctrl_q <= wdata;
         end
         if (target == TGT_PLACE) begin
            place_x <= wdata[31:16];
            place_y <= wdata[15:0];
         end
      end
   end

   for (genvar r = 0; r < CUR_SIZE; r++) begin : g_row
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shape_rows[r] <= '0;
            tint_rows[r]  <= '0;
         end else if (wr && row_sel == ROW_W'(r)) begin
            if (target == TGT_SHAPE) begin
               shape_rows[r] <= wdata;
            end
            if (target == TGT_TINT) begin
               tint_rows[r] <= wdata;
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (target == TGT_CTRL) begin
         rdata = ctrl_q | CTRL_FLAG;
      end
   end
endmodule

// File: rtl/hwcur_locate.sv
module hwcur_locate
   import hwcur_pkg::*;
#(
   parameter int unsigned SCREEN_W = 1024,
   parameter int unsigned CUR_SIZE = 32,
   localparam int unsigned ROW_W   = (CUR_SIZE > 1) ? $clog2(CUR_SIZE) : 1,
   localparam int unsigned WIDE_W  = COORD_W + 1
) (
   input  logic [COORD_W-1:0]               px,
   input  logic [COORD_W-1:0]               py,
   input  logic [COORD_W-1:0]               place_x,
   input  logic [COORD_W-1:0]               place_y,
   input  logic [CUR_SIZE-1:0][REG_W-1:0]   shape_rows,
   input  logic [CUR_SIZE-1:0][REG_W-1:0]   tint_rows,
   output logic                             covered,
   output logic                             tint_bit
);
   logic [WIDE_W-1:0] px_w, py_w, cx_w, cy_w;
   logic [WIDE_W-1:0] dx_w, dy_w;
   logic              in_rows, in_cols, on_screen;
   logic [ROW_W-1:0]  row_idx;
   logic [4:0]        bit_idx;
   logic [REG_W-1:0]  shape_word, tint_word;

   assign px_w = {1'b0, px};
   assign py_w = {1'b0, py};
   assign cx_w = {1'b0, place_x};
   assign cy_w = {1'b0, place_y};
   assign dx_w = px_w - cx_w;
   assign dy_w = py_w - cy_w;

   assign in_rows   = (py_w >= cy_w) && (dy_w < WIDE_W'(CUR_SIZE));
   assign in_cols   = (px_w >= cx_w) && (dx_w < WIDE_W'(CUR_SIZE));
   assign on_screen = (cx_w < WIDE_W'(SCREEN_W)) && (px_w < WIDE_W'(SCREEN_W));

   assign row_idx    = dy_w[ROW_W-1:0];
   assign shape_word = shape_rows[row_idx];
   assign tint_word  = tint_rows[row_idx];

   if (CUR_SIZE == REG_W) begin : g_full_row
      assign bit_idx = 5'(REG_W - 1) - dx_w[4:0];
   end else begin : g_part_row
      assign bit_idx = 5'(REG_W - 1) - 5'(dx_w[ROW_W-1:0]);
   end

   assign covered  = in_rows && in_cols && on_screen && shape_word[bit_idx];
   assign tint_bit = tint_word[bit_idx];
endmodule

// File: rtl/hwcur_overlay.sv
module hwcur_overlay
   import hwcur_pkg::*;
#(
   parameter int unsigned SCREEN_W = 1024,
   parameter int unsigned CUR_SIZE = 32,
   parameter int unsigned IDX_W    = 8,
   localparam int unsigned OUT_W   = IDX_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [11:0]        reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               pix_valid,
   input  logic [15:0]        pix_x,
   input  logic [15:0]        pix_y,
   input  logic [IDX_W-1:0]   pix_index,
   output logic               out_valid,
   output logic [OUT_W-1:0]   out_index
);
   localparam logic [OUT_W-1:0] OVL_LO = OUT_W'((1 << IDX_W) + 2);
   localparam logic [OUT_W-1:0] OVL_HI = OUT_W'((1 << IDX_W) + 3);

   if (CUR_SIZE < 2 || CUR_SIZE > REG_W || (CUR_SIZE & (CUR_SIZE - 1)) != 0) begin : g_bad_size
      $error("CUR_SIZE must be a power of two between 2 and 32");
   end
   if (SCREEN_W < 1 || SCREEN_W >= (1 << COORD_W)) begin : g_bad_width
      $error("SCREEN_W out of coordinate range");
   end
   if (IDX_W < 2 || IDX_W > 16) begin : g_bad_idx
      $error("IDX_W out of range");
   end

   logic [COORD_W-1:0]             place_x, place_y;
   logic [CUR_SIZE-1:0][REG_W-1:0] shape_rows, tint_rows;
   logic                           covered, tint_bit;
   logic [OUT_W-1:0]               next_index;

   hwcur_regs #(.CUR_SIZE(CUR_SIZE)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (reg_wr),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .rdata      (reg_rdata),
      .place_x    (place_x),
      .place_y    (place_y),
      .shape_rows (shape_rows),
      .tint_rows  (tint_rows)
   );

   hwcur_locate #(.SCREEN_W(SCREEN_W), .CUR_SIZE(CUR_SIZE)) u_locate (
      .px         (pix_x),
      .py         (pix_y),
      .place_x    (place_x),
      .place_y    (place_y),
      .shape_rows (shape_rows),
      .tint_rows  (tint_rows),
      .covered    (covered),
      .tint_bit   (tint_bit)
   );

   always_comb begin
      next_index = {1'b0, pix_index};
      if (covered) begin
         next_index = tint_bit ? OVL_HI : OVL_LO;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_index <= '0;
      end else begin
         out_valid <= pix_valid;
         out_index <= next_index;
      end
   end
endmodule

// File: rtl/hwcur_checker.sv
module hwcur_checker #(
   parameter int unsigned SCREEN_W = 1024,
   parameter int unsigned IDX_W    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [11:0]      reg_addr,
   input logic [31:0]      reg_rdata,
   input logic             pix_valid,
   input logic [15:0]      pix_x,
   input logic [15:0]      pix_y,
   input logic [IDX_W-1:0] pix_index,
   input logic             out_valid,
   input logic [IDX_W:0]   out_index,
   input logic [15:0]      place_x,
   input logic [15:0]      place_y
);
   assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(pix_valid));

   assert_overlay_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_index[IDX_W]) |-> (out_index[IDX_W-1:1] == 1));

   assert_above_passes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_y < place_y) |=> (out_index == {1'b0, $past(pix_index)}));

   assert_left_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_x < place_x) |=> (out_index == {1'b0, $past(pix_index)}));

   assert_hidden_cursor_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && 32'(place_x) >= SCREEN_W) |=> (out_index == {1'b0, $past(pix_index)}));

   assert_past_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && 32'(pix_x) >= SCREEN_W) |=> (out_index == {1'b0, $past(pix_index)}));

   assert_ctrl_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 12'h818) |-> reg_rdata[25]);

   assert_other_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr != 12'h818) |-> (reg_rdata == '0));
endmodule

bind hwcur_overlay hwcur_checker #(.SCREEN_W(SCREEN_W), .IDX_W(IDX_W)) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .pix_valid (pix_valid),
   .pix_x     (pix_x),
   .pix_y     (pix_y),
   .pix_index (pix_index),
   .out_valid (out_valid),
   .out_index (out_index),
   .place_x   (place_x),
   .place_y   (place_y)
);

// File: tb/tb_hwcur_overlay.sv
`timescale 1ns/1ps
module tb_hwcur_overlay;
   localparam int W = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        pix_valid = 1'b0;
   logic [15:0] pix_x = '0;
   logic [15:0] pix_y = '0;
   logic [7:0]  pix_index = '0;
   logic        out_valid;
   logic [8:0]  out_index;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   int          m_x = 16'hF000;
   int          m_y = 16'hF000;
   logic [31:0] m_shape [32];
   logic [31:0] m_tint  [32];

   always #2.5 clk = ~clk;

   hwcur_overlay dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_valid(pix_valid),
      .pix_x(pix_x), .pix_y(pix_y), .pix_index(pix_index),
      .out_valid(out_valid), .out_index(out_index)
   );

   function automatic logic [8:0] model(int x, int y, logic [7:0] idx);
      if (y >= m_y && y < m_y + 32 && m_x < W && x >= m_x && x < m_x + 32 && x < W) begin
         if (m_shape[y - m_y][31 - (x - m_x)])
            return m_tint[y - m_y][31 - (x - m_x)] ? 9'h103 : 9'h102;
      end
      return {1'b0, idx};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      if (a == 12'h8FC) begin m_x = int'(d[31:16]); m_y = int'(d[15:0]); end
      if (a >= 12'h900 && a < 12'h980) m_shape[(a - 12'h900) >> 2] = d;
      if (a >= 12'h980 && a < 12'hA00) m_tint[(a - 12'h980) >> 2] = d;
   endtask

   task automatic pixel(string req, int x, int y, logic [7:0] idx);
      logic [8:0] e;
      @(negedge clk);
      pix_valid = 1'b1; pix_x = 16'(x); pix_y = 16'(y); pix_index = idx;
      e = model(x, y, idx);
      @(posedge clk); #1;
      check(req, 32'(out_valid), 32'd1);
      check(req, 32'(out_index), 32'(e));
   endtask

   task automatic t_reset_R1;
      check("R1 valid in reset", 32'(out_valid), 32'd0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 valid after reset", 32'(out_valid), 32'd0);
      pixel("R1 parked cursor", 0, 0, 8'h55);
      pixel("R3 pass-through", 500, 300, 8'hFF);
   endtask

   task automatic t_valid_R2;
      @(negedge clk); pix_valid = 1'b0; pix_index = 8'h11;
      @(posedge clk); #1;
      check("R2 valid follows", 32'(out_valid), 32'd0);
      check("R2 index delayed", 32'(out_index), 32'h11);
   endtask

   task automatic t_regs_R9;
      @(negedge clk); reg_addr = 12'h818; #1;
      check("R9 ctrl reset read", reg_rdata, 32'h0200_0000);
      wr_reg(12'h818, 32'h0000_0055);
      reg_addr = 12'h818; #1;
      check("R9 ctrl stored", reg_rdata, 32'h0200_0055);
      reg_addr = 12'h8FC; #1;
      check("R9 other zero", reg_rdata, 32'h0);
   endtask

   task automatic t_shape_R4_R5;
      wr_reg(12'h8FC, {16'd100, 16'd50});   // R8 X=100 Y=50
      wr_reg(12'h900, 32'hC000_0001);
      wr_reg(12'h980, 32'h4000_0000);
      reg_addr = 12'h900; #1;
      check("R9 mask reads zero", reg_rdata, 32'h0);
      pixel("R5 bit31 at X", 100, 50, 8'h01);
      pixel("R4 tint one", 101, 50, 8'h02);
      pixel("R4 mask zero", 102, 50, 8'h03);
      pixel("R5 bit0 at X+31", 131, 50, 8'h04);
      pixel("R5 right of box", 132, 50, 8'h05);
      pixel("R3 left of box", 99, 50, 8'h06);
   endtask

   task automatic t_rows_R6;
      wr_reg(12'h914, 32'h8000_0000);
      wr_reg(12'h994, 32'h8000_0000);
      wr_reg(12'h97C, 32'hFFFF_FFFF);
      pixel("R6 row 5", 100, 55, 8'h07);
      pixel("R6 row 31", 120, 81, 8'h08);
      pixel("R6 below box", 100, 82, 8'h09);
      pixel("R6 above box", 100, 49, 8'h0A);
      pixel("R8 position field", 100, 50, 8'h0B);
   endtask

   task automatic t_clip_R7;
      wr_reg(12'h8FC, {16'(W - 4), 16'd0});
      wr_reg(12'h900, 32'hFFFF_FFFF);
      pixel("R7 last column", W - 1, 0, 8'h0C);
      pixel("R7 clipped", W, 0, 8'h0D);
      wr_reg(12'h8FC, {16'(W), 16'd0});
      pixel("R7 hidden X", W, 0, 8'h0E);
   endtask

   task automatic t_timing_R10;
      logic [8:0] e_old, e_new;
      wr_reg(12'h8FC, {16'd10, 16'd700});
      wr_reg(12'h980, 32'h0);
      e_old = model(200, 0, 8'h21);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 12'h8FC; reg_wdata = {16'd200, 16'd0};
      pix_valid = 1'b1; pix_x = 16'd200; pix_y = 16'd0; pix_index = 8'h21;
      @(posedge clk); #1;
      check("R10 same cycle old", 32'(out_index), 32'(e_old));
      m_x = 200; m_y = 0;
      e_new = model(200, 0, 8'h21);
      @(negedge clk); reg_wr = 1'b0;
      @(posedge clk); #1;
      check("R10 next cycle new", 32'(out_index), 32'(e_new));
      check("R10 new is overlay", 32'(e_new), 32'h102);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) begin m_shape[i] = '0; m_tint[i] = '0; end
      repeat (3) @(posedge clk);
      #1;
      t_reset_R1;
      t_valid_R2;
      t_regs_R9;
      t_shape_R4_R5;
      t_rows_R6;
      t_clip_R7;
      t_timing_R10;
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         done = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end
endmodule